// File: doc/BRIEF.md
# Transmit Dword FIFO with Free-Byte Threshold

This block is the transmit buffer that sits between a host bus and an Ethernet MAC. The host pushes 32-bit words into it. Each frame is a leading length word followed by the payload padded to whole dwords. The block keeps a byte count of its free space on an output. Software reads that count and pushes a frame only when its padded size plus four bytes fits.

Software controls the block through a small command port made of an opcode and an 11-bit argument. It can arm a free-space threshold, and the block then pulses a tx-available event once when free space reaches that level. It can set a start threshold that tells the drain side how much payload must be buffered before a frame is released to the MAC. It can also enable the transmitter, or clear the buffer after a fault.

The drain side parses each length word itself and passes only payload dwords to the MAC over a valid/ready port. It marks the final dword of each frame and carries the frame's byte length alongside the data. If the MAC asks for data in the middle of a frame and the buffer has run dry, the block flags an underrun and stops until it is cleared.

Top module: `tx_dword_fifo`

## Requirements
- R1: After reset the free count equals DEPTH*4 bytes (256 by default), dr_valid, avail_evt, overrun and underrun are low, and the transmitter is disabled.
- R2: Each accepted host write lowers free_bytes by 4 and each dword removed on the drain side (length word included) raises it by 4, with the new value visible after the clock edge that makes the change.
- R3: The first dword of a frame carries the unpadded byte length in bits 10:0, and bits 31:11 are ignored. It is followed by ceil(length/4) payload dwords. The drain presents only the payload, with dr_last high on the final dword and dr_len equal to the length. A frame of length 0 produces no output.
- R4: Command opcode 18 loads the available threshold from cmd_arg and arms it. One clock after the threshold is armed and free_bytes is at least the threshold, avail_evt is high for exactly one cycle and the threshold is then disarmed. A threshold above the capacity never fires.
- R5: Command opcode 19 sets the start threshold in bytes, which is 2047 after reset. A frame is released when the payload bytes buffered behind its length word reach the start threshold, or when its whole payload is present.
- R6: Command opcode 9 enables the transmitter. While the transmitter is disabled no frame starts and dr_valid stays low.
- R7: A host write while the buffer holds DEPTH dwords is dropped, leaves free_bytes unchanged and sets the sticky overrun flag.
- R8: If dr_ready is high during a frame while the buffer is empty, the sticky underrun flag is set and dr_valid stays low, even after new writes, until a transmit reset.
- R9: Command opcode 11 empties the buffer, so free_bytes reads full on the next cycle. It also clears overrun and underrun and disables the transmitter.
- R10: Command opcodes other than 9, 11, 18 and 19 have no effect.
- R11: While dr_valid is high and dr_ready is low, dr_valid stays high and dr_data stays stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host write strobe, one dword per cycle |
| wr_data | input | 32 | Host write data (length word or payload) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 5 | Command opcode |
| cmd_arg | input | 11 | Command argument |
| free_bytes | output | 9 | Free space in bytes |
| avail_evt | output | 1 | One-cycle pulse when the armed threshold is reached |
| overrun | output | 1 | Sticky flag: a write was dropped because the buffer was full |
| underrun | output | 1 | Sticky flag: the buffer ran dry during a frame |
| dr_ready | input | 1 | MAC accepts the presented dword |
| dr_valid | output | 1 | Payload dword presented to the MAC |
| dr_data | output | 32 | Payload dword |
| dr_last | output | 1 | Final dword of the frame |
| dr_len | output | 11 | Unpadded byte length of the frame being drained |

## Verification
free_bytes, overrun and the cleared state after opcode 11 change at the edge that samples the write or command, so the bench reads them one time unit after that edge. avail_evt goes high one edge after the armed threshold is met and low on the next, and the bench checks both of those exact cycles and also counts pulses on falling edges. A drain transfer happens on the rising edge where dr_valid and dr_ready are both high. The scoreboard compares each transfer on the falling edge before it, against expected payload words that the write tasks queued. The start and underrun cases are judged after fixed idle windows that are longer than the two edges the drain needs to release a frame.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;

    localparam int DW    = 32;
    localparam int LEN_W = 11;
    localparam int PAY_W = LEN_W - 1;
    localparam int CMP_W = 16;

    typedef enum logic [4:0] {
        OP_TX_ENABLE = 5'd9,
        OP_TX_RESET  = 5'd11,
        OP_AVAIL_TH  = 5'd18,
        OP_START_TH  = 5'd19
    } tx_op_e;

    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_SEND = 2'd1,
        DR_HALT = 2'd2
    } drain_st_e;

    typedef struct packed {
        logic             en;
        logic             clr;
        logic             avail_load;
        logic [LEN_W-1:0] avail_val;
        logic [LEN_W-1:0] start_th;
    } ctl_t;

    // Number of whole dwords needed to hold len bytes.
    function automatic logic [PAY_W-1:0] payload_dwords(input logic [LEN_W-1:0] len);
        logic [LEN_W:0] s;
        s = {1'b0, len} + (LEN_W+1)'(3);
        return s[LEN_W:2];
    endfunction

    function automatic logic [CMP_W-1:0] widen(input logic [LEN_W-1:0] v);
        return CMP_W'(v);
    endfunction

endpackage

// File: rtl/txf_cmd_decode.sv
module txf_cmd_decode
    import tx_fifo_pkg::*;
#(
    parameter int START_TH_RST = 2047
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [4:0]       cmd_op,
    input  logic [LEN_W-1:0] cmd_arg,
    output ctl_t             ctl
);

    tx_op_e           op;
    logic             en_q;
    logic [LEN_W-1:0] sth_q;

    assign op = tx_op_e'(cmd_op);

    always_comb begin
        ctl.en         = en_q;
        ctl.start_th   = sth_q;
        ctl.clr        = cmd_valid && (op == OP_TX_RESET);
        ctl.avail_load = cmd_valid && (op == OP_AVAIL_TH);
        ctl.avail_val  = cmd_arg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            sth_q <= LEN_W'(START_TH_RST);
        end else if (cmd_valid) begin
            case (op)
                OP_TX_ENABLE: en_q  <= 1'b1;
                OP_TX_RESET:  en_q  <= 1'b0;
                OP_START_TH:  sth_q <= cmd_arg;
                default:      ;
            endcase
        end
    end

    // R6: an enable command leaves the transmitter enabled
    a_r6_enable_sets: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_TX_ENABLE) |=> en_q);

    // R9: a transmit reset disables the transmitter
    a_r9_reset_disables: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_TX_RESET) |=> !en_q);

endmodule

// File: rtl/txf_avail_mon.sv
module txf_avail_mon
    import tx_fifo_pkg::*;
#(
    parameter int FREE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LEN_W-1:0]  load_val,
    input  logic [FREE_W-1:0] free_bytes,
    output logic              evt
);

    logic [LEN_W-1:0] th_q;
    logic             armed_q;
    logic             evt_q;
    logic             fire;

    assign fire = armed_q && (CMP_W'(free_bytes) >= widen(th_q));
    assign evt  = evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            th_q    <= '0;
            armed_q <= 1'b0;
            evt_q   <= 1'b0;
        end else begin
            evt_q <= fire;
            if (load) begin
                th_q    <= load_val;
                armed_q <= 1'b1;
            end else if (fire) begin
                armed_q <= 1'b0;
            end
        end
    end

    // R4: one pulse per arming, no repeat without a new load
    a_r4_one_shot: assert property (@(posedge clk) disable iff (rst)
        (evt_q && !load) |=> !evt_q);

    // R4: an event is always preceded by an armed threshold
    a_r4_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_q) |-> $past(armed_q));

endmodule

// File: rtl/txf_store.sv
module txf_store
    import tx_fifo_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int CNT_W  = 7,
    parameter int FREE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_valid,
    input  logic [DW-1:0]     wr_data,
    input  logic              pop,
    output logic [DW-1:0]     head,
    output logic [CNT_W-1:0]  count,
    output logic [FREE_W-1:0] free_bytes,
    output logic              overrun
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0]    mem [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [CNT_W-1:0] count_q;
    logic             ovr_q;
    logic             full;
    logic             push;

    assign full       = (count_q == CNT_W'(DEPTH));
    assign push       = wr_valid && !full && !clr;
    assign head       = mem[rptr_q];
    assign count      = count_q;
    assign overrun    = ovr_q;
    assign free_bytes = FREE_W'(DEPTH*4) - FREE_W'({count_q, 2'b00});

    always_ff @(posedge clk) begin
        if (push) mem[wptr_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
            ovr_q   <= 1'b0;
        end else begin
            if (push)
                wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
            if (pop)
                rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: ;
            endcase
            if (wr_valid && full) ovr_q <= 1'b1;
        end
    end

    // R2: occupancy never exceeds the capacity
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

    // R2: the drain never removes from an empty store
    a_r2_no_empty_pop: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count_q != '0));

    // R7: a write into a full store raises the flag and keeps the count
    a_r7_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && full && !clr && !pop) |=> (ovr_q && count_q == CNT_W'(DEPTH)));

    // R9: a clear empties the store
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count_q == '0 && !ovr_q));

endmodule

// File: rtl/txf_drain.sv
module txf_drain
    import tx_fifo_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [LEN_W-1:0] start_th,
    input  logic [CNT_W-1:0] count,
    input  logic [DW-1:0]    head,
    input  logic             dr_ready,
    output logic             pop,
    output logic             dr_valid,
    output logic [DW-1:0]    dr_data,
    output logic             dr_last,
    output logic [LEN_W-1:0] dr_len,
    output logic             underrun
);

    drain_st_e        st_q;
    logic [PAY_W-1:0] rem_q;
    logic [LEN_W-1:0] len_q;
    logic             udr_q;

    logic [LEN_W-1:0] hdr_len;
    logic [PAY_W-1:0] hdr_ndw;
    logic [CMP_W-1:0] have;
    logic             nonempty;
    logic             start_ok;

    always_comb begin
        nonempty = (count != '0);
        hdr_len  = head[LEN_W-1:0];
        hdr_ndw  = payload_dwords(hdr_len);
        have     = CMP_W'(count) - CMP_W'(1);
        start_ok = (have >= CMP_W'(hdr_ndw)) || ((have << 2) >= widen(start_th));
        pop      = 1'b0;
        case (st_q)
            DR_IDLE: pop = en && nonempty && start_ok;
            DR_SEND: pop = dr_ready && nonempty;
            default: pop = 1'b0;
        endcase
    end

    assign dr_valid = (st_q == DR_SEND) && nonempty;
    assign dr_data  = head;
    assign dr_last  = (rem_q == PAY_W'(1));
    assign dr_len   = len_q;
    assign underrun = udr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q  <= DR_IDLE;
            rem_q <= '0;
            len_q <= '0;
            udr_q <= 1'b0;
        end else begin
            case (st_q)
                DR_IDLE: begin
                    if (pop) begin
                        len_q <= hdr_len;
                        rem_q <= hdr_ndw;
                        if (hdr_ndw != '0) st_q <= DR_SEND;
                    end
                end
                DR_SEND: begin
                    if (pop) begin
                        rem_q <= rem_q - 1'b1;
                        if (rem_q == PAY_W'(1)) st_q <= DR_IDLE;
                    end else if (dr_ready) begin
                        udr_q <= 1'b1;
                        st_q  <= DR_HALT;
                    end
                end
                default: st_q <= DR_HALT;
            endcase
        end
    end

    // R8: a halted drain presents nothing
    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        (st_q == DR_HALT) |-> !dr_valid);

    // R6: no frame starts while disabled
    a_r6_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        (st_q == DR_IDLE && !en && !clr) |=> (st_q == DR_IDLE));

    // R11: presented data holds under backpressure
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (dr_valid && !dr_ready && !clr) |=> (dr_valid && $stable(dr_data)));

    // R3: taking the last dword returns to frame parsing
    a_r3_last_ends_frame: assert property (@(posedge clk) disable iff (rst)
        (dr_valid && dr_ready && dr_last && !clr) |=> (st_q == DR_IDLE));

endmodule

// File: rtl/tx_dword_fifo.sv
module tx_dword_fifo
    import tx_fifo_pkg::*;
#(
    parameter int DEPTH        = 64,
    parameter int START_TH_RST = 2047,
    localparam int CNT_W       = $clog2(DEPTH + 1),
    localparam int FREE_W      = $clog2(DEPTH*4 + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [31:0]       wr_data,
    input  logic              cmd_valid,
    input  logic [4:0]        cmd_op,
    input  logic [10:0]       cmd_arg,
    output logic [FREE_W-1:0] free_bytes,
    output logic              avail_evt,
    output logic              overrun,
    output logic              underrun,
    input  logic              dr_ready,
    output logic              dr_valid,
    output logic [31:0]       dr_data,
    output logic              dr_last,
    output logic [10:0]       dr_len
);

    ctl_t             ctl;
    logic             pop;
    logic [DW-1:0]    head;
    logic [CNT_W-1:0] count;

    txf_cmd_decode #(.START_TH_RST(START_TH_RST)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .ctl       (ctl)
    );

    txf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W), .FREE_W(FREE_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clr        (ctl.clr),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .pop        (pop),
        .head       (head),
        .count      (count),
        .free_bytes (free_bytes),
        .overrun    (overrun)
    );

    txf_avail_mon #(.FREE_W(FREE_W)) u_avail (
        .clk        (clk),
        .rst        (rst),
        .load       (ctl.avail_load),
        .load_val   (ctl.avail_val),
        .free_bytes (free_bytes),
        .evt        (avail_evt)
    );

    txf_drain #(.CNT_W(CNT_W)) u_drain (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctl.clr),
        .en       (ctl.en),
        .start_th (ctl.start_th),
        .count    (count),
        .head     (head),
        .dr_ready (dr_ready),
        .pop      (pop),
        .dr_valid (dr_valid),
        .dr_data  (dr_data),
        .dr_last  (dr_last),
        .dr_len   (dr_len),
        .underrun (underrun)
    );

    // R1: nothing is presented while the store is empty
    a_r1_empty_quiet: assert property (@(posedge clk) disable iff (rst)
        (free_bytes == FREE_W'(DEPTH*4)) |-> !dr_valid);

endmodule

// File: tb/tx_dword_fifo_tb.sv
module tx_dword_fifo_tb_top;

    localparam int FREE_W = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid = 1'b0;
    logic [31:0]       wr_data = '0;
    logic              cmd_valid = 1'b0;
    logic [4:0]        cmd_op = '0;
    logic [10:0]       cmd_arg = '0;
    logic [FREE_W-1:0] free_bytes;
    logic              avail_evt;
    logic              overrun;
    logic              underrun;
    logic              dr_ready = 1'b1;
    logic              dr_valid;
    logic [31:0]       dr_data;
    logic              dr_last;
    logic [10:0]       dr_len;

    typedef struct packed {
        logic [31:0] d;
        logic        last;
        logic [10:0] len;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    int   evt_seen = 0;
    bit   done = 1'b0;

    tx_dword_fifo dut_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .free_bytes(free_bytes), .avail_evt(avail_evt), .overrun(overrun),
        .underrun(underrun), .dr_ready(dr_ready), .dr_valid(dr_valid),
        .dr_data(dr_data), .dr_last(dr_last), .dr_len(dr_len)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [31:0] pay(input int len, input int i);
        return 32'hC0DE_0000 | ((len & 32'hFF) << 8) | (i & 32'hFF);
    endfunction

    function automatic int ndw(input int len);
        return (len + 3) / 4;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_valid = 1'b1;
        wr_data  = d;
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    task automatic cmd(input int op, input int arg);
        cmd_valid = 1'b1;
        cmd_op    = 5'(op);
        cmd_arg   = 11'(arg);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    // Length word; upper bits carry junk that must be ignored (R3)
    task automatic send_header(input int len);
        wr({21'h15A5A5, 11'(len)});
    endtask

    // Driver: queues the expected payload, then writes it
    task automatic send_payload(input int len, input int first, input int n, input bit expect_out);
        for (int i = first; i < first + n; i++) begin
            if (expect_out)
                exp_q.push_back('{d: pay(len, i), last: (i == ndw(len) - 1), len: 11'(len)});
            wr(pay(len, i));
        end
    endtask

    // Monitor: compare each transfer before the edge that completes it
    always @(negedge clk) begin
        if (!rst && dr_valid && dr_ready) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected drain dword", dr_data, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R3 drain data", dr_data, e.d);
                chk("R3 drain last", 32'(dr_last), 32'(e.last));
                chk("R3 drain length", 32'(dr_len), 32'(e.len));
            end
        end
        if (avail_evt) evt_seen++;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int base;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        chk("R1 free after reset", 32'(free_bytes), 32'd256);
        chk("R1 dr_valid after reset", 32'(dr_valid), 32'd0);
        chk("R1 overrun after reset", 32'(overrun), 32'd0);
        chk("R1 underrun after reset", 32'(underrun), 32'd0);
        chk("R1 avail_evt after reset", 32'(avail_evt), 32'd0);

        // R2/R6: frame buffered while disabled
        send_header(10);
        send_payload(10, 0, 3, 1'b1);
        chk("R2 free after 4 writes", 32'(free_bytes), 32'd240);
        idle(5);
        chk("R6 no drain while disabled", 32'(dr_valid), 32'd0);

        // R10: unrelated opcode changes nothing
        cmd(4, 0);
        cmd(16, 5);
        idle(5);
        chk("R10 dr_valid after unknown ops", 32'(dr_valid), 32'd0);
        chk("R10 free after unknown ops", 32'(free_bytes), 32'd240);

        // R6/R2/R3: enable drains the frame
        cmd(9, 0);
        idle(10);
        chk("R2 free after drain", 32'(free_bytes), 32'd256);
        chk("R3 scoreboard empty after frame", 32'(exp_q.size()), 32'd0);

        // R5: default start threshold waits for the whole frame
        send_header(20);
        send_payload(20, 0, 2, 1'b1);
        idle(6);
        chk("R5 partial frame held", 32'(dr_valid), 32'd0);
        send_payload(20, 2, 3, 1'b1);
        idle(10);
        chk("R5 whole frame drained", 32'(exp_q.size()), 32'd0);

        // R11: backpressure holds the presented dword
        dr_ready = 1'b0;
        send_header(8);
        send_payload(8, 0, 2, 1'b1);
        idle(5);
        chk("R11 valid under backpressure", 32'(dr_valid), 32'd1);
        chk("R11 data under backpressure", dr_data, pay(8, 0));
        idle(3);
        chk("R11 data still held", dr_data, pay(8, 0));
        dr_ready = 1'b1;
        idle(6);
        chk("R11 drained after release", 32'(exp_q.size()), 32'd0);

        // R3: zero-length frame yields nothing
        send_header(0);
        send_header(5);
        send_payload(5, 0, 2, 1'b1);
        idle(10);
        chk("R3 zero-length then frame", 32'(exp_q.size()), 32'd0);
        chk("R3 free after zero-length", 32'(free_bytes), 32'd256);

        // R5: start threshold of 16 bytes
        cmd(19, 16);
        send_header(40);
        send_payload(40, 0, 3, 1'b1);
        idle(6);
        chk("R5 below start threshold", 32'(dr_valid), 32'd0);
        send_payload(40, 3, 7, 1'b1);
        idle(12);
        chk("R5 threshold frame drained", 32'(exp_q.size()), 32'd0);
        chk("R5 no underrun", 32'(underrun), 32'd0);

        // R8: underrun mid-frame
        cmd(19, 8);
        send_header(32);
        send_payload(32, 0, 2, 1'b1);
        idle(10);
        chk("R8 underrun flag", 32'(underrun), 32'd1);
        chk("R8 halted after underrun", 32'(dr_valid), 32'd0);
        wr(32'h1111_1111);
        wr(32'h2222_2222);
        idle(3);
        chk("R8 still halted after writes", 32'(dr_valid), 32'd0);
        chk("R8 free with two stuck dwords", 32'(free_bytes), 32'd248);

        // R9: transmit reset clears and disables
        cmd(11, 0);
        chk("R9 free after reset command", 32'(free_bytes), 32'd256);
        chk("R9 underrun cleared", 32'(underrun), 32'd0);
        cmd(19, 2047);
        send_header(4);
        send_payload(4, 0, 1, 1'b1);
        idle(5);
        chk("R9 disabled after reset command", 32'(dr_valid), 32'd0);
        cmd(9, 0);
        idle(5);
        chk("R9 runs after re-enable", 32'(exp_q.size()), 32'd0);

        // R7: overrun on full store
        cmd(11, 0);
        for (int i = 0; i < 64; i++) wr(32'hF000_0000 | 32'(i));
        chk("R7 free when full", 32'(free_bytes), 32'd0);
        chk("R7 no overrun before extra write", 32'(overrun), 32'd0);
        wr(32'hDEAD_BEEF);
        chk("R7 overrun flag", 32'(overrun), 32'd1);
        chk("R7 free unchanged", 32'(free_bytes), 32'd0);
        cmd(11, 0);
        chk("R9 overrun cleared", 32'(overrun), 32'd0);
        chk("R9 free after clearing full", 32'(free_bytes), 32'd256);

        // R4: threshold already met fires once, one cycle after load
        base = evt_seen;
        cmd(18, 256);
        chk("R4 evt low at load edge", 32'(avail_evt), 32'd0);
        idle(1);
        chk("R4 evt pulse", 32'(avail_evt), 32'd1);
        idle(1);
        chk("R4 evt single cycle", 32'(avail_evt), 32'd0);
        idle(3);
        chk("R4 one pulse per load", 32'(evt_seen - base), 32'd1);

        // R4: threshold above capacity never fires
        base = evt_seen;
        cmd(18, 300);
        idle(6);
        chk("R4 over-capacity threshold silent", 32'(evt_seen - base), 32'd0);

        // R4: threshold reached later as space is freed
        for (int i = 0; i < 40; i++) wr(32'hE000_0000 | 32'(i));
        chk("R2 free after 40 writes", 32'(free_bytes), 32'd96);
        base = evt_seen;
        cmd(18, 200);
        idle(4);
        chk("R4 no evt below threshold", 32'(evt_seen - base), 32'd0);
        cmd(11, 0);
        idle(1);
        chk("R4 evt after space freed", 32'(avail_evt), 32'd1);
        idle(2);
        chk("R4 single pulse after free", 32'(evt_seen - base), 32'd1);

        chk("R3 scoreboard empty at end", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule